// File: doc/BRIEF.md
# Transmit Descriptor Fetch Engine

This block is the transmit side of a network DMA path. Software builds a chain of two-word descriptors in memory, points the engine at the first one through a queue-base input and, with transmit enabled, pulses a start control. The engine then walks the chain. For each descriptor it reads the buffer address word and the status word, and streams the referenced bytes out one per cycle on a byte interface. The final byte of a frame carries a last marker. When a frame is finished, the engine writes the status word of the frame's first descriptor back to memory with the used flag set.

The chain ends when the engine reads a descriptor that is already marked used. If that happens at a frame boundary, it is a normal stop. If it happens in the middle of a frame, the buffers ran out: the engine stamps the frame's first descriptor as both used and exhausted, then stops. A descriptor carrying the wrap flag sends the engine back to the queue base. A sticky done flag reports completed frames and is cleared by writing one to it.

Each descriptor takes two 32-bit words. Word 0 holds the buffer byte address. Word 1, at byte offset +4, holds the status. Consecutive descriptors sit 8 bytes apart. The memory port is always ready and returns read data exactly one cycle after a read request.

Top module: `txdesc_engine`

## Requirements
- R1: After synchronous reset, stat_busy, stat_done, tx_valid, tx_last, mem_rd and mem_wr are all low.
- R2: A ctl_start pulse while idle starts a run only if ctl_tx_en is 1. The run's first memory read is word 0 at queue_base and its second is word 1 at queue_base+4. With ctl_tx_en at 0 the engine stays idle and makes no memory access.
- R3: Status word fields: bit 31 used, bit 30 wrap, bit 15 last buffer of frame, bits 10:0 buffer length in bytes. Bit 27 is the exhausted flag written by the engine.
- R4: A buffer of length N at byte address A produces exactly N tx_valid beats. They carry memory bytes A, A+1, ... A+N-1, in that order, from little-endian 32-bit words, and any byte alignment of A is allowed.
- R5: tx_last is high only on the final byte of a buffer whose last flag is set.
- R6: A frame may span several descriptors. After a descriptor without wrap, the next one is read at its address plus 8.
- R7: A descriptor whose used bit is set, read at a frame boundary, ends the run. stat_busy drops and nothing more is emitted.
- R8: After a frame's last buffer, the engine writes the first descriptor's status word back with bit 31 set and all other bits as read. No other descriptor of that frame is written.
- R9: stat_done is set when a frame completes. It stays set until a done_clr pulse with no completion in the same cycle clears it.
- R10: After a descriptor with the wrap flag, the next descriptor is read at queue_base.
- R11: A used descriptor read in the middle of a frame sets bits 31 and 27 in the first descriptor's status word. stat_done is not set and the run ends.
- R12: ctl_start while stat_busy is high has no effect. The running frame continues and no restart from queue_base occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_tx_en | input | 1 | Transmit enable |
| ctl_start | input | 1 | Start-transmit pulse |
| queue_base | input | ADDR_W | Byte address of the first descriptor |
| done_clr | input | 1 | Write-one-to-clear for stat_done |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Byte address of the memory word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after mem_rd |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of a frame |
| stat_done | output | 1 | Sticky frame-done flag |
| stat_busy | output | 1 | Engine is running a chain |

## Verification
The checker module checks these rules on every cycle:
- A start honoured while idle issues its first read at the queue base.
- A start without enable leaves the engine idle.
- Read and write requests never overlap.
- Every write-back carries the used flag.
- Output beats occur only while the engine is busy, and the last marker only on a valid beat.
- The done flag rises only right after a write-back and falls after a clear.

The directed scenarios cover the behaviour that depends on memory contents and whole sequences:
- Byte order across unaligned buffers.
- Frames spanning descriptors.
- Wrap back to the base, including the trap descriptor it must skip.
- Exhaustion stamping.
- Which descriptor words are, or are not, rewritten.
- A start ignored mid-frame.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;

    localparam int LEN_W      = 11;
    localparam int BIT_USED   = 31;
    localparam int BIT_WRAP   = 30;
    localparam int BIT_UNDER  = 28;
    localparam int BIT_EXHAUST = 27;
    localparam int BIT_LAST   = 15;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH_A,
        S_FETCH_S,
        S_EVAL,
        S_RDWORD,
        S_EMIT,
        S_ADVANCE,
        S_WRBACK
    } seq_state_t;

    typedef struct packed {
        logic             used;
        logic             wrap;
        logic             last;
        logic [LEN_W-1:0] len;
    } desc_stat_t;

    function automatic desc_stat_t decode_stat(input logic [31:0] w);
        desc_stat_t d;
        d.used = w[BIT_USED];
        d.wrap = w[BIT_WRAP];
        d.last = w[BIT_LAST];
        d.len  = w[LEN_W-1:0];
        return d;
    endfunction

    function automatic logic [31:0] wb_word(input logic [31:0] orig, input logic exhausted);
        logic [31:0] w;
        w = orig;
        w[BIT_USED] = 1'b1;
        if (exhausted) w[BIT_EXHAUST] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/txdesc_seq.sv
module txdesc_seq
    import txdesc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              start,
    input  logic [ADDR_W-1:0] qbase,
    input  logic [31:0]       mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic              emit,
    output logic              emit_fresh,
    output logic [1:0]        emit_sel,
    output logic              emit_last,
    output logic              set_done,
    output logic              busy
);

    localparam logic [ADDR_W-1:0] WORD_OFS = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] DESC_OFS = ADDR_W'(8);

    seq_state_t        state;
    logic [ADDR_W-1:0] cur;
    logic [ADDR_W-1:0] first;
    logic [31:0]       first_stat;
    logic [ADDR_W-1:0] buf_ptr;
    logic [LEN_W-1:0]  rem;
    logic              cur_last;
    logic              cur_wrap;
    logic              in_frame;
    logic              fresh;
    logic              exh;
    desc_stat_t        ds;

    assign ds = decode_stat(mem_rdata);

    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            S_FETCH_A: begin mem_rd = 1'b1; mem_addr = cur; end
            S_FETCH_S: begin mem_rd = 1'b1; mem_addr = cur + WORD_OFS; end
            S_RDWORD:  begin mem_rd = 1'b1; mem_addr = {buf_ptr[ADDR_W-1:2], 2'b00}; end
            S_WRBACK: begin
                mem_wr    = 1'b1;
                mem_addr  = first + WORD_OFS;
                mem_wdata = wb_word(first_stat, exh);
            end
            default: ;
        endcase
    end

    assign emit       = (state == S_EMIT);
    assign emit_fresh = fresh;
    assign emit_sel   = buf_ptr[1:0];
    assign emit_last  = cur_last && (rem == LEN_W'(1));
    assign set_done   = (state == S_WRBACK) && !exh;
    assign busy       = (state != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            cur        <= '0;
            first      <= '0;
            first_stat <= '0;
            buf_ptr    <= '0;
            rem        <= '0;
            cur_last   <= 1'b0;
            cur_wrap   <= 1'b0;
            in_frame   <= 1'b0;
            fresh      <= 1'b0;
            exh        <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start && tx_en) begin
                        cur      <= qbase;
                        in_frame <= 1'b0;
                        exh      <= 1'b0;
                        state    <= S_FETCH_A;
                    end
                end
                S_FETCH_A: state <= S_FETCH_S;
                S_FETCH_S: begin
                    buf_ptr <= mem_rdata[ADDR_W-1:0];
                    state   <= S_EVAL;
                end
                S_EVAL: begin
                    if (ds.used) begin
                        if (in_frame) begin
                            exh   <= 1'b1;
                            state <= S_WRBACK;
                        end else begin
                            state <= S_IDLE;
                        end
                    end else begin
                        if (!in_frame) begin
                            first      <= cur;
                            first_stat <= mem_rdata;
                            in_frame   <= 1'b1;
                        end
                        rem      <= ds.len;
                        cur_last <= ds.last;
                        cur_wrap <= ds.wrap;
                        state    <= (ds.len == '0) ? S_ADVANCE : S_RDWORD;
                    end
                end
                S_RDWORD: begin
                    fresh <= 1'b1;
                    state <= S_EMIT;
                end
                S_EMIT: begin
                    fresh   <= 1'b0;
                    buf_ptr <= buf_ptr + ADDR_W'(1);
                    rem     <= rem - LEN_W'(1);
                    if (rem == LEN_W'(1))
                        state <= S_ADVANCE;
                    else if (buf_ptr[1:0] == 2'b11)
                        state <= S_RDWORD;
                end
                S_ADVANCE: begin
                    cur   <= cur_wrap ? qbase : cur + DESC_OFS;
                    state <= cur_last ? S_WRBACK : S_FETCH_A;
                end
                S_WRBACK: begin
                    in_frame <= 1'b0;
                    exh      <= 1'b0;
                    state    <= exh ? S_IDLE : S_FETCH_A;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/txdesc_lane.sv
module txdesc_lane (
    input  logic        clk,
    input  logic        rst,
    input  logic        emit,
    input  logic        emit_fresh,
    input  logic [1:0]  emit_sel,
    input  logic        emit_last,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last
);

    logic [31:0] wbuf;
    logic [31:0] word;

    assign word = emit_fresh ? mem_rdata : wbuf;

    always_ff @(posedge clk) begin
        if (rst) begin
            wbuf     <= '0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
            tx_last  <= 1'b0;
        end else begin
            tx_valid <= emit;
            tx_last  <= emit && emit_last;
            if (emit) begin
                wbuf    <= word;
                tx_data <= word[8*emit_sel +: 8];
            end
        end
    end

endmodule

// File: rtl/txdesc_status.sv
module txdesc_status (
    input  logic clk,
    input  logic rst,
    input  logic set_done,
    input  logic clr_done,
    output logic done
);

    always_ff @(posedge clk) begin
        if (rst)
            done <= 1'b0;
        else if (set_done)
            done <= 1'b1;
        else if (clr_done)
            done <= 1'b0;
    end

endmodule

// File: rtl/txdesc_engine.sv
module txdesc_engine #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_tx_en,
    input  logic              ctl_start,
    input  logic [ADDR_W-1:0] queue_base,
    input  logic              done_clr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              stat_done,
    output logic              stat_busy
);

    logic       emit;
    logic       emit_fresh;
    logic [1:0] emit_sel;
    logic       emit_last;
    logic       set_done;

    txdesc_seq #(.ADDR_W(ADDR_W)) i_seq (
        .clk        (clk),
        .rst        (rst),
        .tx_en      (ctl_tx_en),
        .start      (ctl_start),
        .qbase      (queue_base),
        .mem_rdata  (mem_rdata),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .emit       (emit),
        .emit_fresh (emit_fresh),
        .emit_sel   (emit_sel),
        .emit_last  (emit_last),
        .set_done   (set_done),
        .busy       (stat_busy)
    );

    txdesc_lane i_lane (
        .clk        (clk),
        .rst        (rst),
        .emit       (emit),
        .emit_fresh (emit_fresh),
        .emit_sel   (emit_sel),
        .emit_last  (emit_last),
        .mem_rdata  (mem_rdata),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_last    (tx_last)
    );

    txdesc_status i_status (
        .clk      (clk),
        .rst      (rst),
        .set_done (set_done),
        .clr_done (done_clr),
        .done     (stat_done)
    );

endmodule

// File: rtl/txdesc_engine_chk.sv
module txdesc_engine_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ctl_tx_en,
    input logic              ctl_start,
    input logic [ADDR_W-1:0] queue_base,
    input logic              done_clr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              tx_valid,
    input logic              tx_last,
    input logic              stat_done,
    input logic              stat_busy
);

    // R2
    start_fetch_base_chk: assert property (@(posedge clk) disable iff (rst)
        (!stat_busy && ctl_start && ctl_tx_en) |=> (mem_rd && mem_addr == $past(queue_base)));

    // R2
    start_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (!stat_busy && ctl_start && !ctl_tx_en) |=> (!stat_busy && !mem_rd && !mem_wr));

    // R8
    wb_used_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> mem_wdata[31]);

    // R8
    no_rw_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R4
    beat_busy_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> stat_busy);

    // R5
    last_valid_chk: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid);

    // R9
    done_after_wb_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_done) |-> $past(mem_wr));

    // R9
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (done_clr && !mem_wr) |=> !stat_done);

endmodule

bind txdesc_engine txdesc_engine_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .ctl_tx_en  (ctl_tx_en),
    .ctl_start  (ctl_start),
    .queue_base (queue_base),
    .done_clr   (done_clr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .tx_valid   (tx_valid),
    .tx_last    (tx_last),
    .stat_done  (stat_done),
    .stat_busy  (stat_busy)
);

// File: tb/test_txdesc_engine.sv
`timescale 1ns/1ps
module test_txdesc_engine;

    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic              ctl_tx_en;
    logic              ctl_start;
    logic [ADDR_W-1:0] queue_base;
    logic              done_clr;
    logic              mem_rd;
    logic              mem_wr;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata;
    logic              tx_valid;
    logic [7:0]        tx_data;
    logic              tx_last;
    logic              stat_done;
    logic              stat_busy;

    int errors = 0;
    int checks = 0;
    logic [31:0] mem [0:255];
    logic [7:0]  got_b [0:63];
    logic        got_l [0:63];
    int          ng = 0;

    always #2 clk = ~clk;

    txdesc_engine #(.ADDR_W(ADDR_W)) i_txdesc_engine (
        .clk(clk), .rst(rst), .ctl_tx_en(ctl_tx_en), .ctl_start(ctl_start),
        .queue_base(queue_base), .done_clr(done_clr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .stat_done(stat_done), .stat_busy(stat_busy)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
        if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
    end

    always @(negedge clk) begin
        if (tx_valid && ng < 64) begin
            got_b[ng] = tx_data;
            got_l[ng] = tx_last;
            ng = ng + 1;
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_desc(input int a, input logic [31:0] baddr, input logic [31:0] st);
        mem[a >> 2]       = baddr;
        mem[(a >> 2) + 1] = st;
    endtask

    task automatic clear_done();
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
    endtask

    task automatic run_chain(input logic [31:0] qb);
        ng = 0;
        @(negedge clk);
        queue_base = qb; ctl_start = 1'b1;
        @(negedge clk); ctl_start = 1'b0;
        for (int i = 0; i < 3000 && stat_busy; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_seg(input int from, input int baddr, input int len,
                             input logic lastend, input string tag);
        for (int i = 0; i < len; i++) begin
            check(got_b[from+i] == pat(baddr+i), tag, got_b[from+i], pat(baddr+i));
            check(got_l[from+i] == (lastend && i == len-1), "R5 last marker",
                  got_l[from+i], lastend && i == len-1);
        end
    endtask

    task automatic t_reset();
        check(!stat_busy, "R1 busy", stat_busy, 0);
        check(!stat_done, "R1 done", stat_done, 0);
        check(!tx_valid && !tx_last, "R1 tx", tx_valid, 0);
        check(!mem_rd && !mem_wr, "R1 mem", mem_rd | mem_wr, 0);
    endtask

    task automatic t_no_enable();
        ctl_tx_en = 1'b0;
        set_desc(32'h100, 32'h200, 32'h0000_8004);
        set_desc(32'h108, 0, 32'h8000_0000);
        run_chain(32'h100);
        check(ng == 0, "R2 start ignored when disabled", ng, 0);
        check(!stat_busy, "R2 stays idle", stat_busy, 0);
        check(mem[32'h104 >> 2] == 32'h0000_8004, "R2 no writeback", mem[32'h104 >> 2], 32'h0000_8004);
        ctl_tx_en = 1'b1;
    endtask

    task automatic t_single();
        set_desc(32'h100, 32'h201, 32'h0000_8006);
        set_desc(32'h108, 0, 32'h8000_0000);
        run_chain(32'h100);
        check(ng == 6, "R4 byte count", ng, 6);
        check_seg(0, 32'h201, 6, 1'b1, "R4 unaligned bytes");
        check(mem[32'h104 >> 2] == 32'h8000_8006, "R8 writeback", mem[32'h104 >> 2], 32'h8000_8006);
        check(stat_done, "R9 done set", stat_done, 1);
        check(!stat_busy, "R7 stop on used", stat_busy, 0);
        clear_done();
        @(negedge clk);
        check(!stat_done, "R9 done cleared", stat_done, 0);
    endtask

    task automatic t_multi();
        set_desc(32'h120, 32'h240, 32'h0000_0003);
        set_desc(32'h128, 32'h262, 32'h0000_8005);
        set_desc(32'h130, 0, 32'h8000_0000);
        run_chain(32'h120);
        check(ng == 8, "R6 spanning count", ng, 8);
        check_seg(0, 32'h240, 3, 1'b0, "R6 first buffer");
        check_seg(3, 32'h262, 5, 1'b1, "R6 second buffer");
        check(mem[32'h124 >> 2] == 32'h8000_0003, "R8 first desc used", mem[32'h124 >> 2], 32'h8000_0003);
        check(mem[32'h12C >> 2] == 32'h0000_8005, "R8 other desc untouched", mem[32'h12C >> 2], 32'h0000_8005);
        clear_done();
    endtask

    task automatic t_wrap();
        int nl;
        set_desc(32'h180, 32'h2A0, 32'h0000_8002);
        set_desc(32'h188, 32'h2B1, 32'h4000_8003);
        set_desc(32'h190, 32'h2C0, 32'h0000_8004);
        run_chain(32'h180);
        nl = 0;
        for (int i = 0; i < ng; i++) nl += int'(got_l[i]);
        check(ng == 5, "R10 wrap byte count", ng, 5);
        check(nl == 2, "R10 two frames", nl, 2);
        check_seg(0, 32'h2A0, 2, 1'b1, "R10 frame A");
        check_seg(2, 32'h2B1, 3, 1'b1, "R10 frame B");
        check(mem[32'h194 >> 2] == 32'h0000_8004, "R10 trap desc skipped", mem[32'h194 >> 2], 32'h0000_8004);
        check(mem[32'h18C >> 2] == 32'hC000_8003, "R3 wrap desc used", mem[32'h18C >> 2], 32'hC000_8003);
        check(!stat_busy, "R7 stopped at base", stat_busy, 0);
        clear_done();
    endtask

    task automatic t_exhaust();
        set_desc(32'h1A0, 32'h2E3, 32'h0000_0004);
        set_desc(32'h1A8, 0, 32'h8000_0000);
        run_chain(32'h1A0);
        check(ng == 4, "R11 bytes before exhaustion", ng, 4);
        check_seg(0, 32'h2E3, 4, 1'b0, "R11 bytes");
        check(mem[32'h1A4 >> 2] == 32'h8800_0004, "R11 exhausted stamp", mem[32'h1A4 >> 2], 32'h8800_0004);
        check(!stat_done, "R11 no done", stat_done, 0);
        check(!stat_busy, "R11 stopped", stat_busy, 0);
    endtask

    task automatic t_busy_start();
        set_desc(32'h1C0, 32'h300, 32'h0000_8014);
        set_desc(32'h1C8, 0, 32'h8000_0000);
        set_desc(32'h1E0, 32'h380, 32'h0000_8004);
        set_desc(32'h1E8, 0, 32'h8000_0000);
        ng = 0;
        @(negedge clk);
        queue_base = 32'h1C0; ctl_start = 1'b1;
        @(negedge clk); ctl_start = 1'b0;
        repeat (12) @(negedge clk);
        check(stat_busy, "R12 busy mid frame", stat_busy, 1);
        queue_base = 32'h1E0; ctl_start = 1'b1;
        @(negedge clk); ctl_start = 1'b0;
        for (int i = 0; i < 3000 && stat_busy; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        check(ng == 20, "R12 no restart", ng, 20);
        check_seg(0, 32'h300, 20, 1'b1, "R12 bytes");
        check(mem[32'h1E4 >> 2] == 32'h0000_8004, "R12 other chain untouched", mem[32'h1E4 >> 2], 32'h0000_8004);
        clear_done();
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int w = 0; w < 256; w++)
            mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
        rst = 1'b1; ctl_tx_en = 1'b0; ctl_start = 1'b0;
        queue_base = '0; done_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_enable();
        t_single();
        t_multi();
        t_wrap();
        t_exhaust();
        t_busy_start();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule